// File: doc/BRIEF.md
# UART Modem Status and Control

This block holds the modem-handshake state of one UART channel. Four active-low modem inputs (carrier detect, data set ready, clear to send and ring indicator) pass through a synchronizer. They are shown, inverted to active-high, in the upper nibble of a modem status register. The lower nibble holds sticky change flags. The flags clear when the CPU reads the status register. A modem-status interrupt is raised while any flag is pending and the interrupt enable bit is set.

A modem control register drives four active-low outputs: terminal ready, request to send and two general outputs. It also holds a loopback bit. In loopback the status nibble takes its values from the control register instead of the pins. A strap input is captured while reset is held. It decides whether the terminal-ready pin is forced inactive during loopback or still follows its control bit. The CPU reaches the registers through a plain read/write strobe with a 2-bit address. Read data is combinational in the strobe cycle.

Top module: `uart_modem_ctl`

## Requirements
- R1: MSR status bits read active-high: bit 7 is NOT dcd_n, bit 6 is NOT ri_n, bit 5 is NOT dsr_n and bit 4 is NOT cts_n. A pin change shows after two clock edges of synchronization.
- R2: MSR delta bits are sticky. Bit 3 sets on any change of the carrier status, bit 1 on any change of the data-set-ready status and bit 0 on any change of the clear-to-send status. Bit 2 sets only when the ring status falls from 1 to 0.
- R3: A read of the MSR clears all delta bits at the clock edge that ends the read cycle. A status change detected at that same edge still sets its delta bit.
- R4: irq is high exactly when enable register bit 0 is 1 and at least one delta bit is set. It drops once the deltas are cleared by a read.
- R5: MCR bits are: bit 0 terminal ready, bit 1 request to send, bit 2 general output 1, bit 3 general output 2 and bit 4 loopback. Bits 7:5 read as 0. Outside loopback each output pin is low exactly when its bit is 1. Reset clears the MCR, so every output pin is high.
- R6: With MCR bit 4 set, the status bits come from the MCR and the input pins are ignored: carrier from bit 3, ring from bit 2, data set ready from bit 0 and clear to send from bit 1. rts_n, out1_n and out2_n are held high.
- R7: strap_dtr_hold is sampled while rst_n is low. If it was 1, dtr_n stays high throughout loopback. If it was 0, dtr_n follows MCR bit 0 in loopback too.
- R8: The modem inputs have no effect on any output pin or on the MCR contents.
- R9: The register map is: address 0 is the enable register (bit 0 only, other bits read 0), address 1 is the MCR and address 2 is the MSR. The MSR is read-only and writes to it are ignored. Address 3 reads 0. reg_rdata is 0 whenever reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap_dtr_hold | input | 1 | Strap, captured during reset: hold terminal-ready inactive in loopback |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the read cycle |
| dcd_n | input | 1 | Carrier detect, active low |
| dsr_n | input | 1 | Data set ready, active low |
| cts_n | input | 1 | Clear to send, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |
| irq | output | 1 | Modem-status interrupt, active high |

## Verification
Random pin toggles with reads at random spacing check that deltas build up across several changes between reads, which a flag-per-read design would miss. Ring rising and falling edges are mixed so that the trailing-edge-only rule shows apart from plain change detection. Random MCR writes switch loopback on and off under both strap values; this separates pin-sourced from register-sourced status and shows the strap-dependent terminal-ready behaviour. One directed case lands a status change on the exact edge of a clearing read, which tells a set-wins clear from a clear-wins one.

// File: rtl/umc_pkg.sv
package umc_pkg;
  localparam int NSIG = 4;
  // Index of each modem signal in the internal status nibble (matches MSR bit order)
  localparam int IX_CTS = 0;
  localparam int IX_DSR = 1;
  localparam int IX_RI  = 2;
  localparam int IX_DCD = 3;

  typedef enum logic [1:0] {
    A_IEN = 2'd0,
    A_MCR = 2'd1,
    A_MSR = 2'd2,
    A_RSV = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mcr_t;

  localparam int MCR_W = $bits(mcr_t);
endpackage

// File: rtl/umc_sync.sv
module umc_sync #(
  parameter int          W      = 4,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/umc_status.sv
module umc_status
  import umc_pkg::*;
#(
  parameter int N = NSIG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cur,
  input  logic         clr,
  output logic [N-1:0] chg,
  output logic [N-1:0] delta
);
  logic [N-1:0] prev_q;
  logic [N-1:0] delta_q;

  for (genvar i = 0; i < N; i++) begin : g_edge
    if (i == IX_RI) begin : g_trail
      assign chg[i] = prev_q[i] & ~cur[i];
    end else begin : g_any
      assign chg[i] = prev_q[i] ^ cur[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      delta_q <= '0;
    end else begin
      prev_q  <= cur;
      // a fresh change wins over a clearing read
      delta_q <= (clr ? '0 : delta_q) | chg;
    end
  end

  assign delta = delta_q;
endmodule

// File: rtl/umc_ctrl.sv
module umc_ctrl
  import umc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_i,
  input  logic              wr,
  input  reg_addr_e         addr,
  input  logic [DATA_W-1:0] wdata,
  output mcr_t              mcr,
  output logic              ien,
  output logic              strap_q,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n
);
  mcr_t mcr_q;
  logic ien_q;
  logic strap_r;
  logic wdata_unused;

  assign wdata_unused = ^wdata[DATA_W-1:MCR_W];

  // strap captured for as long as reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) strap_r <= strap_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcr_q <= '0;
      ien_q <= 1'b0;
    end else if (wr) begin
      if (addr == A_MCR) mcr_q <= mcr_t'(wdata[MCR_W-1:0]);
      if (addr == A_IEN) ien_q <= wdata[0];
    end
  end

  logic dtr_act;
  assign dtr_act = mcr_q.dtr & ~(mcr_q.loop & strap_r);

  assign dtr_n   = ~dtr_act;
  assign rts_n   = ~(mcr_q.rts  & ~mcr_q.loop);
  assign out1_n  = ~(mcr_q.out1 & ~mcr_q.loop);
  assign out2_n  = ~(mcr_q.out2 & ~mcr_q.loop);
  assign mcr     = mcr_q;
  assign ien     = ien_q;
  assign strap_q = strap_r;
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import umc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_dtr_hold,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dcd_n,
  input  logic              dsr_n,
  input  logic              cts_n,
  input  logic              ri_n,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n,
  output logic              irq
);
  reg_addr_e        addr;
  logic [NSIG-1:0]  pins_n, pins_sync_n, loop_src, stat_cur, stat_chg, delta_q;
  mcr_t             mcr_q;
  logic             ien_q, strap_q, msr_clr;

  assign addr = reg_addr_e'(reg_addr);

  assign pins_n[IX_DCD] = dcd_n;
  assign pins_n[IX_RI]  = ri_n;
  assign pins_n[IX_DSR] = dsr_n;
  assign pins_n[IX_CTS] = cts_n;

  umc_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (pins_n),
    .q (pins_sync_n)
  );

  umc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk (clk),
    .rst_n (rst_n),
    .strap_i (strap_dtr_hold),
    .wr (reg_wr),
    .addr (addr),
    .wdata (reg_wdata),
    .mcr (mcr_q),
    .ien (ien_q),
    .strap_q (strap_q),
    .dtr_n (dtr_n),
    .rts_n (rts_n),
    .out1_n (out1_n),
    .out2_n (out2_n)
  );

  // loopback wiring of control bits onto status inputs
  assign loop_src[IX_DCD] = mcr_q.out2;
  assign loop_src[IX_RI]  = mcr_q.out1;
  assign loop_src[IX_DSR] = mcr_q.dtr;
  assign loop_src[IX_CTS] = mcr_q.rts;

  assign stat_cur = mcr_q.loop ? loop_src : ~pins_sync_n;
  assign msr_clr  = reg_rd && (addr == A_MSR);

  umc_status #(.N(NSIG)) u_status (
    .clk (clk),
    .rst_n (rst_n),
    .cur (stat_cur),
    .clr (msr_clr),
    .chg (stat_chg),
    .delta (delta_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (addr)
        A_IEN: reg_rdata[0] = ien_q;
        A_MCR: reg_rdata[MCR_W-1:0] = mcr_q;
        A_MSR: reg_rdata[2*NSIG-1:0] = {stat_cur, delta_q};
        A_RSV: reg_rdata = '0;
      endcase
    end
  end

  assign irq = ien_q & (|delta_q);
endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       msr_clr,
  input logic [3:0] chg,
  input logic [3:0] delta,
  input logic       loop,
  input logic       dtr_bit,
  input logic       strap_q,
  input logic       dtr_n_o,
  input logic       rts_n_o,
  input logic       irq_o,
  input logic       ien
);
  // R2: pending flags survive while no clearing read
  a_r2_delta_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !msr_clr |=> ((delta & $past(delta)) == $past(delta)));

  // R2: a detected change is recorded
  a_r2_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|chg) |=> ((delta & $past(chg)) == $past(chg)));

  // R3: a read with no coincident change empties the flags
  a_r3_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_clr && chg == 4'b0) |=> (delta == 4'b0));

  // R4: interrupt requires enable and drops after a clean read
  a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ien);
  a_r4_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_clr && chg == 4'b0) |=> !irq_o);

  // R5: terminal ready is only driven active when its bit is set
  a_r5_dtr_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !dtr_n_o |-> dtr_bit);

  // R6: request to send idles in loopback
  a_r6_rts_idle_loop: assert property (@(posedge clk) disable iff (!rst_n)
    loop |-> rts_n_o);

  // R7: strap holds terminal ready inactive in loopback
  a_r7_dtr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (loop && strap_q) |-> dtr_n_o);
endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .msr_clr (msr_clr),
  .chg (stat_chg),
  .delta (delta_q),
  .loop (mcr_q.loop),
  .dtr_bit (mcr_q.dtr),
  .strap_q (strap_q),
  .dtr_n_o (dtr_n),
  .rts_n_o (rts_n),
  .irq_o (irq),
  .ien (ien_q)
);

// File: tb/uart_modem_ctl_tb.sv
module uart_modem_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       dcd_n = 1'b1, dsr_n = 1'b1, cts_n = 1'b1, ri_n = 1'b1;
  logic       dtr_n, rts_n, out1_n, out2_n, irq;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic [4:0] m_mcr;
  logic       m_ien, m_strap;
  logic [3:0] m_cur, m_delta;

  always #2 clk = ~clk;

  uart_modem_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .strap_dtr_hold(strap),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dcd_n(dcd_n), .dsr_n(dsr_n), .cts_n(cts_n), .ri_n(ri_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
    .irq(irq)
  );

  // status nibble order {dcd, ri, dsr, cts}
  function automatic logic [3:0] cur_of(input logic [4:0] m, input logic [3:0] pn);
    return m[4] ? {m[3], m[2], m[0], m[1]} : ~pn;
  endfunction

  function automatic logic [3:0] chg_of(input logic [3:0] p, input logic [3:0] n);
    logic [3:0] c;
    c = p ^ n;
    c[2] = p[2] & ~n[2];
    return c;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd1) m_mcr = d[4:0];
    if (a == 2'd0) m_ien = d[0];
  endtask

  task automatic do_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic settle();
    logic [3:0] nc;
    repeat (4) @(negedge clk);
    nc = cur_of(m_mcr, {dcd_n, ri_n, dsr_n, cts_n});
    m_delta = m_delta | chg_of(m_cur, nc);
    m_cur = nc;
  endtask

  task automatic read_msr(input string req);
    logic [7:0] d;
    do_read(2'd2, d);
    check(req, d, {m_cur, m_delta});
    m_delta = 4'b0;
  endtask

  task automatic check_pins(input string req);
    logic lp;
    lp = m_mcr[4];
    check({req, " dtr_n"}, {7'b0, dtr_n}, {7'b0, ~(m_mcr[0] & ~(lp & m_strap))});
    check({req, " rts_n"}, {7'b0, rts_n}, {7'b0, ~(m_mcr[1] & ~lp)});
    check({req, " out1_n"}, {7'b0, out1_n}, {7'b0, ~(m_mcr[2] & ~lp)});
    check({req, " out2_n"}, {7'b0, out2_n}, {7'b0, ~(m_mcr[3] & ~lp)});
  endtask

  task automatic check_irq(input string req);
    check(req, {7'b0, irq}, {7'b0, m_ien & (|m_delta)});
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0; strap = s;
    dcd_n = 1'b1; dsr_n = 1'b1; cts_n = 1'b1; ri_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    strap = ~s;                      // strap must only matter during reset
    m_mcr = '0; m_ien = 1'b0; m_strap = s; m_cur = '0; m_delta = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240611));
    do_reset(1'b0);

    // reset state: R5, R1, R4
    check_pins("R5 reset");
    check_irq("R4 reset");
    do_read(2'd1, d); check("R5 reset mcr", d, 8'h00);
    read_msr("R1 reset msr");

    // R1/R2 carrier assert, then R3 clear
    dcd_n = 1'b0; settle();
    read_msr("R1 R2 dcd change");
    read_msr("R3 cleared");

    // R2 ring trailing edge only
    ri_n = 1'b0; settle(); read_msr("R2 ri leading no flag");
    ri_n = 1'b1; settle(); read_msr("R2 ri trailing flag");

    // R4 interrupt raise and drop
    do_write(2'd0, 8'hFF); settle();
    dsr_n = 1'b0; settle();
    check_irq("R4 irq raised");
    read_msr("R4 read");
    check_irq("R4 irq dropped");

    // R3 change on the clearing edge survives
    @(negedge clk); cts_n = 1'b0;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    reg_rd = 1'b1; reg_addr = 2'd2;
    #1 check("R3 same-edge read", reg_rdata, 8'hB0);
    @(negedge clk); reg_rd = 1'b0;
    m_cur = 4'b1011; m_delta = 4'b0001;
    read_msr("R3 same-edge delta kept");

    // R8 modem pins do not touch outputs or MCR
    do_write(2'd1, 8'h0F); settle();
    for (int k = 0; k < 4; k++) begin
      dcd_n = ~dcd_n; cts_n = ~cts_n; settle();
      check_pins("R8 pins stable");
    end
    do_read(2'd1, d); check("R8 mcr unchanged", d, 8'h0F);
    read_msr("R8 msr");

    // R9 map
    do_write(2'd2, 8'hFF); settle();
    read_msr("R9 msr write ignored");
    do_read(2'd3, d); check("R9 addr3 zero", d, 8'h00);
    do_read(2'd0, d); check("R9 ien readback", d, {7'b0, m_ien});
    #1 check("R9 rdata idle", reg_rdata, 8'h00);

    // R6/R7 loopback with both strap values
    for (int s = 0; s < 2; s++) begin
      do_reset(s[0]);
      do_write(2'd1, 8'h11); settle();
      check_pins("R7 loop dtr strap");
      read_msr("R6 loop status");
      dcd_n = 1'b0; ri_n = 1'b0; settle();
      read_msr("R6 pins ignored in loop");
      do_write(2'd1, 8'h1E); settle();
      check_pins("R6 loop outputs idle");
      read_msr("R6 loop mapping");
      do_write(2'd1, 8'h00); settle();
      read_msr("R6 leave loop");
    end

    // random phase
    do_reset(1'b1);
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom % 5;
      case (op)
        0, 1: begin
          {dcd_n, ri_n, dsr_n, cts_n} = 4'($urandom);
          settle();
        end
        2: begin do_write(2'd1, 8'($urandom)); settle(); end
        3: begin do_write(2'd0, 8'($urandom)); settle(); end
        default: begin
          if ($urandom % 2 == 0) read_msr("R2 R3 random msr");
          else begin do_read(2'd1, d); check("R5 random mcr", d, {3'b0, m_mcr}); end
        end
      endcase
      check_irq("R4 random irq");
      check_pins("R5 R6 R7 random pins");
      if (it == 300) do_reset(1'b0);
    end

    finish_run();
  end
endmodule